// File: doc/BRIEF.md
# Read-After-Write Issue Interlock

This block sits between decode and execute of an in-order, single-issue pipeline. Every cycle it looks at the one decoded instruction waiting to issue. It decides whether that instruction may go now, or whether it must wait because one of its source registers will be written by an earlier instruction whose result is not yet usable. Each instruction carries an operation class, an optional destination register and up to two source registers, each with its own use flag. The number of bubbles depends on both the class that writes the register and the class that reads it.

A table of per-register entries records, for each register, the class of its last writer and how many cycles have passed since that writer issued. The wait needed for a source is the bubble count for that writer/reader pair minus the elapsed cycles, floored at zero. The instruction waits for the largest such value among its used sources. A flush input cancels the waiting instruction in the same cycle and leaves the table untouched. Forwarding paths, renaming and branch delay slots are not part of this block.

Top module: `ilk_interlock`

## Requirements
- R1: After reset no register is pending, so any valid instruction issues in its first cycle. With `in_valid` low, `issue` and `stall` are both low.
- R2: Class codes are 0 FP arithmetic, 1 load, 2 store, 3 integer, 4 branch. An FP arithmetic result read by another FP arithmetic instruction forces 3 bubbles.
- R3: A store uses source A as its address and source B as its data. An FP arithmetic result read as store data forces 2 bubbles.
- R4: A load result read by FP arithmetic forces 1 bubble. A load result read as store data forces none.
- R5: An integer result read by another integer instruction forces no bubble. An integer result read by a branch as its condition (source A) forces 1 bubble.
- R6: Every writer/reader pair not named in R2 to R5 forces no bubble. This includes any value read as a store address.
- R7: Only read-after-write dependences stall. Writing a register that an earlier instruction reads, or writing one that is already pending, issues at once. The newest write replaces the older entry, so later readers wait only for the newest writer.
- R8: With both sources pending, the wait is the larger of the two remaining counts.
- R9: `issue` and `stall` are never high together. `wait_cnt` shows the bubbles still needed. While a held instruction stalls, `wait_cnt` drops by one per cycle, and the number of stall cycles equals the first value shown.
- R10: While `flush` is high, neither `issue` nor `stall` is asserted and nothing is recorded. Entries of already issued instructions keep ageing.
- R11: A source whose use flag is low never causes a stall.
- R12: The scalar-add loop (load, FP add, store, pointer decrement, branch) issues once every 9 cycles in its plain order. Reordered as load, decrement, add, store, branch, it issues once every 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is waiting |
| in_class | input | 3 | Operation class code |
| in_dst | input | IDXW | Destination register index |
| in_wr | input | 1 | Instruction writes `in_dst` |
| in_src_a | input | IDXW | Source A index (store address, branch condition) |
| in_use_a | input | 1 | Source A is read |
| in_src_b | input | IDXW | Source B index (store data) |
| in_use_b | input | 1 | Source B is read |
| flush | input | 1 | Cancel the waiting instruction this cycle |
| issue | output | 1 | Instruction leaves at the coming edge |
| stall | output | 1 | Instruction is held |
| wait_cnt | output | BW | Bubbles still required |

## Verification
On every cycle the assertions check these rules: the handshake outputs never overlap, flush blocks issue, a stall always shows a non-zero wait, the wait counts down by one while the same instruction is held, and an FP reader placed right behind its FP writer is never let through. The exact bubble count for each class pair, the replacement of an entry by a newer writer, the max rule over two sources, and the steady 9- and 7-cycle loop rates depend on whole instruction sequences. Only the bench's directed scenarios can show them.

// File: rtl/ilk_pkg.sv
// Shared definitions for the issue interlock: operation classes and the
// writer/reader bubble table. Assumes in-order completion of writes.
package ilk_pkg;
    typedef enum logic [2:0] {
        OP_FPALU  = 3'd0,
        OP_LOAD   = 3'd1,
        OP_STORE  = 3'd2,
        OP_INT    = 3'd3,
        OP_BRANCH = 3'd4
    } op_cls_t;

    localparam int MAX_BUBBLE = 3;
    localparam int BW         = $clog2(MAX_BUBBLE + 1);
    localparam int NSRC       = 2;

    // Bubbles a reader of class cons needs after a writer of class prod.
    function automatic logic [BW-1:0] bubbles(op_cls_t prod, op_cls_t cons);
        logic [BW-1:0] n;
        n = '0;
        case (prod)
            OP_FPALU: begin
                if (cons == OP_FPALU) n = BW'(3);
                else if (cons == OP_STORE) n = BW'(2);
            end
            OP_LOAD:  if (cons == OP_FPALU) n = BW'(1);
            OP_INT:   if (cons == OP_BRANCH) n = BW'(1);
            default:  n = '0;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/ilk_scoreboard.sv
// Per-register record of the last writer's class and the cycles elapsed
// since it issued. Age saturates at MAX_BUBBLE. A new write replaces the
// entry. Assumes one write per cycle at most.
module ilk_scoreboard
    import ilk_pkg::*;
#(
    parameter int REGS = 64,
    localparam int IDXW = $clog2(REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDXW-1:0]           wr_idx,
    input  logic [2:0]                wr_cls,
    input  logic [NSRC-1:0][IDXW-1:0] rd_idx,
    output logic [NSRC-1:0]           rd_pend,
    output logic [NSRC-1:0][2:0]      rd_cls,
    output logic [NSRC-1:0][BW-1:0]   rd_age
);
    logic          pend_q [REGS];
    logic [2:0]    cls_q  [REGS];
    logic [BW-1:0] age_q  [REGS];

    for (genvar r = 0; r < REGS; r++) begin : g_ent
        // Record a new writer or age the existing entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[r] <= 1'b0;
                cls_q[r]  <= 3'd0;
                age_q[r]  <= '0;
            end else if (wr_en && (wr_idx == IDXW'(r))) begin
                pend_q[r] <= 1'b1;
                cls_q[r]  <= wr_cls;
                age_q[r]  <= '0;
            end else if (age_q[r] != BW'(MAX_BUBBLE)) begin
                age_q[r]  <= age_q[r] + BW'(1);
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_rd
        assign rd_pend[s] = pend_q[rd_idx[s]];
        assign rd_cls[s]  = cls_q[rd_idx[s]];
        assign rd_age[s]  = age_q[rd_idx[s]];
    end
endmodule

// File: rtl/ilk_hazard.sv
// Works out the remaining bubbles for each used source from the writer's
// class, the reader's class and the elapsed age, then takes the maximum.
// A store's source 0 is its address and is treated as an integer read.
module ilk_hazard
    import ilk_pkg::*;
(
    input  logic [2:0]              cons_cls,
    input  logic [NSRC-1:0]         use_src,
    input  logic [NSRC-1:0]         pend,
    input  logic [NSRC-1:0][2:0]    pcls,
    input  logic [NSRC-1:0][BW-1:0] age,
    output logic [BW-1:0]           wait_max
);
    logic [NSRC-1:0][BW-1:0] rem;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        op_cls_t       eff;
        logic [BW-1:0] need;
        // Remaining bubbles for this source.
        always_comb begin
            eff  = (op_cls_t'(cons_cls) == OP_STORE && s == 0) ? OP_INT : op_cls_t'(cons_cls);
            need = bubbles(op_cls_t'(pcls[s]), eff);
            rem[s] = '0;
            if (use_src[s] && pend[s] && (need > age[s])) rem[s] = need - age[s];
        end
    end

    // Largest remaining count over all sources.
    always_comb begin
        wait_max = '0;
        for (int s = 0; s < NSRC; s++)
            if (rem[s] > wait_max) wait_max = rem[s];
    end
endmodule

// File: rtl/ilk_interlock.sv
// Top of the issue interlock. Issues the waiting instruction when no used
// source needs further bubbles and flush is low. Otherwise holds it.
// Assumes the instruction is held stable at the inputs until it issues or is flushed.
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int REGS = 64,
    localparam int IDXW = $clog2(REGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      in_class,
    input  logic [IDXW-1:0] in_dst,
    input  logic            in_wr,
    input  logic [IDXW-1:0] in_src_a,
    input  logic            in_use_a,
    input  logic [IDXW-1:0] in_src_b,
    input  logic            in_use_b,
    input  logic            flush,
    output logic            issue,
    output logic            stall,
    output logic [BW-1:0]   wait_cnt
);
    logic [NSRC-1:0][IDXW-1:0] rd_idx;
    logic [NSRC-1:0]           rd_pend;
    logic [NSRC-1:0][2:0]      rd_cls;
    logic [NSRC-1:0][BW-1:0]   rd_age;
    logic [BW-1:0]             need_wait;

    assign rd_idx = {in_src_b, in_src_a};

    ilk_scoreboard #(.REGS(REGS)) u_sb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (issue && in_wr),
        .wr_idx (in_dst),
        .wr_cls (in_class),
        .rd_idx (rd_idx),
        .rd_pend(rd_pend),
        .rd_cls (rd_cls),
        .rd_age (rd_age)
    );

    ilk_hazard u_hz (
        .cons_cls(in_class),
        .use_src ({in_use_b, in_use_a}),
        .pend    (rd_pend),
        .pcls    (rd_cls),
        .age     (rd_age),
        .wait_max(need_wait)
    );

    // Issue/stall decision for the waiting instruction.
    always_comb begin
        issue    = in_valid && !flush && (need_wait == '0);
        stall    = in_valid && !flush && (need_wait != '0);
        wait_cnt = need_wait;
    end
endmodule

// File: rtl/ilk_checker.sv
// Cycle-level rules of the interlock, attached to every instance by bind.
module ilk_checker
    import ilk_pkg::*;
#(
    parameter int IDXW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      in_class,
    input logic [IDXW-1:0] in_dst,
    input logic            in_wr,
    input logic [IDXW-1:0] in_src_a,
    input logic            in_use_a,
    input logic [IDXW-1:0] in_src_b,
    input logic            in_use_b,
    input logic            flush,
    input logic            issue,
    input logic            stall,
    input logic [BW-1:0]   wait_cnt
);
    // R9
    excl_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && stall));

    // R10
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!issue && !stall));

    // R9
    stall_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (wait_cnt != '0));

    // R9
    countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ((in_valid && !flush && $stable(in_class) && $stable(in_src_a) &&
                    $stable(in_src_b) && $stable(in_use_a) && $stable(in_use_b))
                   -> (wait_cnt == $past(wait_cnt) - BW'(1))));

    // R2
    fp_fp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_wr && in_class == 3'd0) |=>
        !(issue && in_class == 3'd0 && in_use_a && in_src_a == $past(in_dst)));
endmodule

bind ilk_interlock ilk_checker #(.IDXW(IDXW)) u_ilk_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_dst(in_dst), .in_wr(in_wr), .in_src_a(in_src_a), .in_use_a(in_use_a),
    .in_src_b(in_src_b), .in_use_b(in_use_b), .flush(flush), .issue(issue),
    .stall(stall), .wait_cnt(wait_cnt)
);

// File: tb/test_ilk_interlock.sv
module test_ilk_interlock;
    localparam int IDXW = 6;
    localparam int FP = 0, LD = 1, ST = 2, IN = 3, BR = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_wr = 0, in_use_a = 0, in_use_b = 0, flush = 0;
    logic [2:0] in_class = '0;
    logic [IDXW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic issue, stall;
    logic [1:0] wait_cnt;
    int cyc = 0, total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    ilk_interlock i_ilk_interlock (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_wr(in_wr), .in_src_a(in_src_a), .in_use_a(in_use_a),
        .in_src_b(in_src_b), .in_use_b(in_use_b), .flush(flush),
        .issue(issue), .stall(stall), .wait_cnt(wait_cnt)
    );

    function automatic logic [IDXW-1:0] fr(int n); return IDXW'(32 + n); endfunction
    function automatic logic [IDXW-1:0] ir(int n); return IDXW'(n); endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Present one instruction and hold it until it issues.
    task automatic send(int cls, logic [IDXW-1:0] dst, bit wr,
                        logic [IDXW-1:0] sa, bit ua, logic [IDXW-1:0] sb, bit ub,
                        output int stalls, output int first_wait, output int at);
        @(negedge clk);
        in_valid = 1; in_class = 3'(cls); in_dst = dst; in_wr = wr;
        in_src_a = sa; in_use_a = ua; in_src_b = sb; in_use_b = ub;
        stalls = 0;
        #1 first_wait = int'(wait_cnt);
        while (!issue && stalls < 20) begin
            stalls++;
            @(negedge clk); #1;
        end
        at = cyc;
        @(posedge clk); #1 in_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        int s, w, a;
        @(negedge clk); #1;
        check("R1 idle issue", int'(issue), 0);
        check("R1 idle stall", int'(stall), 0);
        send(FP, fr(4), 1, fr(0), 1, fr(2), 1, s, w, a);
        check("R1 first issue", s, 0);
        idle(5);
    endtask

    task automatic t_pair(string req, int pc, int cc, bit on_b, int exp);
        int s, w, a;
        send(pc, fr(6), 1, ir(9), 0, ir(9), 0, s, w, a);
        if (on_b) send(cc, fr(8), cc != ST && cc != BR, ir(3), 1, fr(6), 1, s, w, a);
        else      send(cc, fr(8), cc != ST && cc != BR, fr(6), 1, ir(3), 0, s, w, a);
        check(req, s, exp);
        check({req, " first wait"}, w, exp);
        idle(5);
    endtask

    task automatic t_names();
        int s, w, a;
        // R7 write-after-read
        send(FP, fr(4), 1, fr(2), 1, fr(0), 1, s, w, a);
        send(LD, fr(2), 1, ir(1), 1, ir(0), 0, s, w, a);
        check("R7 WAR", s, 0);
        idle(5);
        // R7 write-after-write, newest writer wins
        send(FP, fr(4), 1, ir(0), 0, ir(0), 0, s, w, a);
        send(LD, fr(4), 1, ir(1), 1, ir(0), 0, s, w, a);
        check("R7 WAW issue", s, 0);
        send(FP, fr(10), 1, fr(4), 1, fr(2), 1, s, w, a);
        check("R7 newest writer", s, 1);
        idle(5);
    endtask

    task automatic t_two_src();
        int s, w, a;
        send(FP, fr(4), 1, ir(0), 0, ir(0), 0, s, w, a);
        send(LD, fr(0), 1, ir(1), 1, ir(0), 0, s, w, a);
        send(FP, fr(10), 1, fr(0), 1, fr(4), 1, s, w, a);
        check("R8 max of sources", s, 2);
        idle(5);
    endtask

    task automatic t_unused();
        int s, w, a;
        send(FP, fr(4), 1, ir(0), 0, ir(0), 0, s, w, a);
        send(FP, fr(10), 1, fr(4), 0, fr(4), 0, s, w, a);
        check("R11 unused source", s, 0);
        idle(5);
    endtask

    task automatic t_flush();
        int s, w, a;
        send(FP, fr(4), 1, ir(0), 0, ir(0), 0, s, w, a);
        @(negedge clk);
        in_valid = 1; in_class = 3'(FP); in_dst = fr(12); in_wr = 1;
        in_src_a = fr(4); in_use_a = 1; in_use_b = 0; flush = 1;
        #1;
        check("R10 flush issue", int'(issue), 0);
        check("R10 flush stall", int'(stall), 0);
        @(posedge clk); #1 flush = 0; in_valid = 0;
        send(FP, fr(12), 1, fr(4), 1, ir(0), 0, s, w, a);
        check("R10 entry kept ageing", s, 2);
        idle(5);
    endtask

    task automatic t_loop(bit sched, int exp);
        int s, w, a, prev;
        prev = -1;
        for (int it = 0; it < 3; it++) begin
            send(LD, fr(0), 1, ir(1), 1, ir(0), 0, s, w, a);
            if (prev >= 0) check(sched ? "R12 scheduled loop" : "R12 plain loop", a - prev, exp);
            prev = a;
            if (sched) begin
                send(IN, ir(1), 1, ir(1), 1, ir(0), 0, s, w, a);
                send(FP, fr(4), 1, fr(0), 1, fr(2), 1, s, w, a);
                send(ST, ir(0), 0, ir(1), 1, fr(4), 1, s, w, a);
            end else begin
                send(FP, fr(4), 1, fr(0), 1, fr(2), 1, s, w, a);
                send(ST, ir(0), 0, ir(1), 1, fr(4), 1, s, w, a);
                send(IN, ir(1), 1, ir(1), 1, ir(0), 0, s, w, a);
            end
            send(BR, ir(0), 0, ir(1), 1, ir(0), 0, s, w, a);
        end
        idle(5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_pair("R2 fp->fp", FP, FP, 0, 3);
        t_pair("R3 fp->store data", FP, ST, 1, 2);
        t_pair("R4 load->fp", LD, FP, 0, 1);
        t_pair("R4 load->store data", LD, ST, 1, 0);
        t_pair("R5 int->int", IN, IN, 0, 0);
        t_pair("R5 int->branch", IN, BR, 0, 1);
        t_pair("R6 fp->store address", FP, ST, 0, 0);
        t_pair("R6 load->branch", LD, BR, 0, 0);
        t_pair("R6 fp->int", FP, IN, 0, 0);
        t_names();
        t_two_src();
        t_unused();
        t_flush();
        t_loop(0, 9);
        t_loop(1, 7);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule